// File: doc/BRIEF.md
# Status and Control Flag Register

This block keeps the 16-bit flags word that sits beside a 16-bit ALU able to operate on whole words or on single bytes. Each cycle it is told the class of the operation being retired, the operand size, both operands, the ALU result and the ALU carry-out. From these it derives the six status flags: carry, parity, half-carry, zero, sign and overflow. It also carries the three control flags: trap, interrupt enable and direction.

Arithmetic classes rewrite all six status flags. Logical operations rewrite parity, zero and sign, and force carry, half-carry and overflow to zero. Data moves and control transfers leave the word untouched. Single-flag commands set, clear or complement the carry flag, and set or clear the interrupt-enable and direction flags. A full-word load, as from a popped stack word, is the only way to change the trap flag.

The flags word and every defined flag bit are driven straight from registers, so a change appears one clock after the operation is presented.

Top module: `status_flag_unit`

## Requirements
- R1: Synchronous active-high `rst` sets the flags word to 16'hF002. The bit layout is: carry bit 0, parity bit 2, half-carry bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt enable bit 9, direction bit 10, overflow bit 11. Bits 15:12 and bit 1 always read 1. Bits 3 and 5 always read 0.
- R2: `op_cls` codes are 0 none, 1 add, 2 subtract, 3 logic, 4 flag command and 5 word load. Codes 0, 6 and 7 leave the flags word unchanged, whatever the other inputs are.
- R3: For add (1), carry takes `carry_out`. Overflow is 1 exactly when the signed sum of the sized operands lies outside the signed range of that size; for example, byte 7Fh + 01h sets it.
- R4: For subtract (2), carry takes `carry_out` (the borrow). Overflow is 1 exactly when the signed difference a - b lies outside the signed range of the operand size.
- R5: For add, subtract and logic, parity is 1 when `result[7:0]` holds an even number of ones (zero ones counts as even), in both sizes.
- R6: For add, half-carry is 1 when a[3:0] + b[3:0] exceeds 15. For subtract, half-carry is 1 when a[3:0] < b[3:0].
- R7: For add, subtract and logic, zero is 1 when the sized result (`result[7:0]` when `byte_op`=1, otherwise all 16 bits) is zero. Sign copies bit 7 of the result when `byte_op`=1 and bit 15 otherwise.
- R8: For logic (3), carry, half-carry and overflow become 0.
- R9: With `op_cls`=4, `flag_cmd` 0 clears carry, 1 sets carry and 2 complements carry.
- R10: With `op_cls`=4, `flag_cmd` 3 clears interrupt enable, 4 sets it, 5 clears direction and 6 sets direction. Code 7 changes nothing.
- R11: Trap, interrupt enable and direction are unchanged by add, subtract and logic. Trap is also unchanged by every flag command.
- R12: Word load (5) copies `opnd_a` into the nine defined flag bits. The fixed bits keep their constant values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_cls | input | 3 | Operation class |
| flag_cmd | input | 3 | Single-flag command, used when op_cls is 4 |
| byte_op | input | 1 | 1 selects byte size, 0 selects word size |
| opnd_a | input | 16 | First ALU operand, or the word to load |
| opnd_b | input | 16 | Second ALU operand |
| result | input | 16 | ALU result |
| carry_out | input | 1 | ALU carry or borrow out of the sized operation |
| flags_o | output | 16 | Registered flags word |
| cf_o | output | 1 | Carry flag |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Half-carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| tf_o | output | 1 | Trap flag |
| ie_o | output | 1 | Interrupt enable flag |
| df_o | output | 1 | Direction flag |
| of_o | output | 1 | Overflow flag |

## Verification
Every flag is a register that drives a port directly, so a wrong next-state choice shows up one clock later as a wrong bit of `flags_o`. A control flag disturbed by an arithmetic or command cycle stays wrong until the next word load. Because of that, the bench loads the control flags to known values before the arithmetic sweeps, and it compares the whole word after every operation. A wrong size selection shows up only for operands whose byte and word views differ, so the byte operands keep upper bytes that differ from the low byte's sign.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int FLAG_W = 16;

  // operation classes
  localparam logic [2:0] OPC_NONE  = 3'd0;
  localparam logic [2:0] OPC_ADD   = 3'd1;
  localparam logic [2:0] OPC_SUB   = 3'd2;
  localparam logic [2:0] OPC_LOGIC = 3'd3;
  localparam logic [2:0] OPC_CMD   = 3'd4;
  localparam logic [2:0] OPC_LOAD  = 3'd5;

  // single-flag commands
  localparam logic [2:0] CMD_CCLR = 3'd0;
  localparam logic [2:0] CMD_CSET = 3'd1;
  localparam logic [2:0] CMD_CINV = 3'd2;
  localparam logic [2:0] CMD_ICLR = 3'd3;
  localparam logic [2:0] CMD_ISET = 3'd4;
  localparam logic [2:0] CMD_DCLR = 3'd5;
  localparam logic [2:0] CMD_DSET = 3'd6;

  // bit positions in the flags word (software sees this layout)
  localparam int P_CF = 0;
  localparam int P_PF = 2;
  localparam int P_AF = 4;
  localparam int P_ZF = 6;
  localparam int P_SF = 7;
  localparam int P_TF = 8;
  localparam int P_IE = 9;
  localparam int P_DF = 10;
  localparam int P_OF = 11;

  localparam logic [FLAG_W-1:0] DEF_MASK =
    (FLAG_W'(1) << P_CF) | (FLAG_W'(1) << P_PF) | (FLAG_W'(1) << P_AF) |
    (FLAG_W'(1) << P_ZF) | (FLAG_W'(1) << P_SF) | (FLAG_W'(1) << P_TF) |
    (FLAG_W'(1) << P_IE) | (FLAG_W'(1) << P_DF) | (FLAG_W'(1) << P_OF);
  localparam logic [FLAG_W-1:0] FIXED_VAL = 16'hF002;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } status_t;
endpackage

// File: rtl/sfu_status_calc.sv
module sfu_status_calc
  import sfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              is_sub,
  input  logic              byte_op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  input  logic              cout,
  output status_t           st
);
  localparam int MSB_W = DATA_W - 1;
  localparam int MSB_B = BYTE_W - 1;

  logic a_msb, b_msb, r_msb;
  logic zero_b, zero_w;
  logic ovf_add, ovf_sub;

  always_comb begin
    a_msb   = byte_op ? a[MSB_B] : a[MSB_W];
    b_msb   = byte_op ? b[MSB_B] : b[MSB_W];
    r_msb   = byte_op ? r[MSB_B] : r[MSB_W];
    zero_b  = (r[BYTE_W-1:0] == '0);
    zero_w  = (r == '0);
    ovf_add = (a_msb == b_msb) && (r_msb != a_msb);
    ovf_sub = (a_msb != b_msb) && (r_msb != a_msb);

    st.cf = cout;
    st.pf = ~(^r[BYTE_W-1:0]);
    st.af = a[NIB_W] ^ b[NIB_W] ^ r[NIB_W];
    st.zf = byte_op ? zero_b : zero_w;
    st.sf = r_msb;
    st.of = is_sub ? ovf_sub : ovf_add;
  end
endmodule

// File: rtl/sfu_cmd_decode.sv
module sfu_cmd_decode
  import sfu_pkg::*;
(
  input  logic [2:0] cmd,
  input  logic       cf_cur,
  input  logic       ie_cur,
  input  logic       df_cur,
  output logic       cf_nxt,
  output logic       ie_nxt,
  output logic       df_nxt
);
  always_comb begin
    cf_nxt = cf_cur;
    ie_nxt = ie_cur;
    df_nxt = df_cur;
    case (cmd)
      CMD_CCLR: cf_nxt = 1'b0;
      CMD_CSET: cf_nxt = 1'b1;
      CMD_CINV: cf_nxt = ~cf_cur;
      CMD_ICLR: ie_nxt = 1'b0;
      CMD_ISET: ie_nxt = 1'b1;
      CMD_DCLR: df_nxt = 1'b0;
      CMD_DSET: df_nxt = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_cls,
  input  logic [2:0]        flag_cmd,
  input  logic              byte_op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              carry_out,
  output logic [FLAG_W-1:0] flags_o,
  output logic              cf_o,
  output logic              pf_o,
  output logic              af_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              tf_o,
  output logic              ie_o,
  output logic              df_o,
  output logic              of_o
);
  localparam int LOAD_W = (DATA_W < FLAG_W) ? DATA_W : FLAG_W;

  status_t          st;
  logic             cf_c, ie_c, df_c;
  logic [FLAG_W-1:0] nxt;
  logic [FLAG_W-1:0] load_word;

  sfu_status_calc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_calc (
    .is_sub  (op_cls == OPC_SUB),
    .byte_op (byte_op),
    .a       (opnd_a),
    .b       (opnd_b),
    .r       (result),
    .cout    (carry_out),
    .st      (st)
  );

  sfu_cmd_decode u_cmd (
    .cmd    (flag_cmd),
    .cf_cur (flags_o[P_CF]),
    .ie_cur (flags_o[P_IE]),
    .df_cur (flags_o[P_DF]),
    .cf_nxt (cf_c),
    .ie_nxt (ie_c),
    .df_nxt (df_c)
  );

  always_comb begin
    load_word = '0;
    load_word[LOAD_W-1:0] = opnd_a[LOAD_W-1:0];
  end

  always_comb begin
    nxt = flags_o;
    case (op_cls)
      OPC_ADD, OPC_SUB: begin
        nxt[P_CF] = st.cf;
        nxt[P_PF] = st.pf;
        nxt[P_AF] = st.af;
        nxt[P_ZF] = st.zf;
        nxt[P_SF] = st.sf;
        nxt[P_OF] = st.of;
      end
      OPC_LOGIC: begin
        nxt[P_CF] = 1'b0;
        nxt[P_PF] = st.pf;
        nxt[P_AF] = 1'b0;
        nxt[P_ZF] = st.zf;
        nxt[P_SF] = st.sf;
        nxt[P_OF] = 1'b0;
      end
      OPC_CMD: begin
        nxt[P_CF] = cf_c;
        nxt[P_IE] = ie_c;
        nxt[P_DF] = df_c;
      end
      OPC_LOAD: nxt = load_word;
      default:  ;
    endcase
  end

  // defined positions are flops, all others are tied constants
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (DEF_MASK[i]) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst) flags_o[i] <= 1'b0;
        else     flags_o[i] <= nxt[i];
      end
    end else begin : g_tie
      assign flags_o[i] = FIXED_VAL[i];
    end
  end

  assign cf_o = flags_o[P_CF];
  assign pf_o = flags_o[P_PF];
  assign af_o = flags_o[P_AF];
  assign zf_o = flags_o[P_ZF];
  assign sf_o = flags_o[P_SF];
  assign tf_o = flags_o[P_TF];
  assign ie_o = flags_o[P_IE];
  assign df_o = flags_o[P_DF];
  assign of_o = flags_o[P_OF];
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
  import sfu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_cls,
  input logic [2:0]        flag_cmd,
  input logic              byte_op,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flags_o,
  input logic              cf_o,
  input logic              zf_o,
  input logic              of_o,
  input logic              af_o,
  input logic              tf_o,
  input logic              ie_o
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_cls == OPC_NONE || op_cls > OPC_LOAD) |=> $stable(flags_o)); // R2
  AST_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_cls == OPC_ADD && byte_op && result[7:0] == 8'h00) |=> zf_o); // R7
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (op_cls == OPC_LOGIC) |=> (!cf_o && !of_o && !af_o)); // R8
  AST_CARRY_INVERT: assert property (@(posedge clk) disable iff (rst)
    (op_cls == OPC_CMD && flag_cmd == CMD_CINV) |=> (cf_o != $past(cf_o))); // R9
  AST_IE_SET: assert property (@(posedge clk) disable iff (rst)
    (op_cls == OPC_CMD && flag_cmd == CMD_ISET) |=> ie_o); // R10
  AST_TRAP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (op_cls != OPC_LOAD) |=> $stable(tf_o)); // R11
  AST_LOAD_TRAP: assert property (@(posedge clk) disable iff (rst)
    (op_cls == OPC_LOAD) |=> (tf_o == $past(opnd_a[P_TF]))); // R12
endmodule

bind status_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_sfu_chk (
  .clk      (clk),
  .rst      (rst),
  .op_cls   (op_cls),
  .flag_cmd (flag_cmd),
  .byte_op  (byte_op),
  .opnd_a   (opnd_a),
  .result   (result),
  .flags_o  (flags_o),
  .cf_o     (cf_o),
  .zf_o     (zf_o),
  .of_o     (of_o),
  .af_o     (af_o),
  .tf_o     (tf_o),
  .ie_o     (ie_o)
);

// File: tb/tb_status_flag_unit.sv
module tb_status_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] M_DEF = 16'h0FD5;
  localparam logic [15:0] M_FIX = 16'hF002;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_cls = 3'd0;
  logic [2:0]  flag_cmd = 3'd7;
  logic        byte_op = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0, result = '0;
  logic        carry_out = 1'b0;
  logic [15:0] flags_o;
  logic        cf_o, pf_o, af_o, zf_o, sf_o, tf_o, ie_o, df_o, of_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] expf;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_unit dut (
    .clk(clk), .rst(rst), .op_cls(op_cls), .flag_cmd(flag_cmd), .byte_op(byte_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .carry_out(carry_out),
    .flags_o(flags_o), .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o), .zf_o(zf_o),
    .sf_o(sf_o), .tf_o(tf_o), .ie_o(ie_o), .df_o(df_o), .of_o(of_o)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: flags actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic even_low(input logic [15:0] r);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(r[i]);
    return (c % 2) == 0;
  endfunction

  function automatic int sval(input logic [15:0] v, input logic bo);
    return bo ? int'($signed(v[7:0])) : int'($signed(v));
  endfunction

  // drive one operation, model the expected word, compare one cycle later
  task automatic run_op(input logic [2:0] op, input logic [2:0] cmd, input logic bo,
                        input logic [15:0] a, input logic [15:0] b, input string tag);
    logic [15:0] r;
    logic        co;
    int          s, lo, hi, ua, ub, mask;
    mask = bo ? 255 : 65535;
    lo = bo ? -128 : -32768;
    hi = bo ? 127 : 32767;
    ua = int'(a) & mask;
    ub = int'(b) & mask;
    r = a; co = 1'b0;
    if (op == 3'd1) begin
      s = ua + ub; co = (s > mask);
      r = bo ? {a[15:8], 8'(s)} : 16'(s);
    end else if (op == 3'd2) begin
      s = ua - ub; co = (s < 0);
      r = bo ? {a[15:8], 8'(s)} : 16'(s);
    end else if (op == 3'd3) begin
      r = a ^ b;
    end
    case (op)
      3'd1, 3'd2, 3'd3: begin
        expf[2] = even_low(r);                                   // R5
        expf[6] = bo ? (r[7:0] == 0) : (r == 0);                 // R7
        expf[7] = bo ? r[7] : r[15];                             // R7
        if (op == 3'd3) begin
          expf[0] = 0; expf[4] = 0; expf[11] = 0;                // R8
        end else if (op == 3'd1) begin
          s = sval(a, bo) + sval(b, bo);
          expf[0] = co; expf[11] = (s < lo) || (s > hi);         // R3
          expf[4] = (int'(a[3:0]) + int'(b[3:0])) > 15;          // R6
        end else begin
          s = sval(a, bo) - sval(b, bo);
          expf[0] = co; expf[11] = (s < lo) || (s > hi);         // R4
          expf[4] = a[3:0] < b[3:0];                             // R6
        end
      end
      3'd4: case (cmd)
        3'd0: expf[0] = 0;
        3'd1: expf[0] = 1;
        3'd2: expf[0] = ~expf[0];
        3'd3: expf[9] = 0;
        3'd4: expf[9] = 1;
        3'd5: expf[10] = 0;
        3'd6: expf[10] = 1;
        default: ;
      endcase
      3'd5: expf = (a & M_DEF) | M_FIX;
      default: ;
    endcase
    op_cls = op; flag_cmd = cmd; byte_op = bo;
    opnd_a = a; opnd_b = b; result = r; carry_out = co;
    @(negedge clk);
    cmp(tag, flags_o, expf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] bv;
    logic [15:0] wa, wb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expf = M_FIX;
    cmp("R1 reset", flags_o, 16'hF002);

    // R9 carry commands, R10 interrupt/direction commands
    run_op(3'd4, 3'd1, 0, 16'hFFFF, 0, "R9 set carry");
    run_op(3'd4, 3'd2, 0, 0, 0, "R9 invert carry");
    run_op(3'd4, 3'd2, 0, 0, 0, "R9 invert carry again");
    run_op(3'd4, 3'd0, 0, 0, 0, "R9 clear carry");
    run_op(3'd4, 3'd4, 0, 0, 0, "R10 set ie");
    run_op(3'd4, 3'd6, 0, 0, 0, "R10 set df");
    run_op(3'd4, 3'd7, 0, 16'hFFFF, 16'hFFFF, "R10 code 7 no change");
    run_op(3'd4, 3'd3, 0, 0, 0, "R10 clear ie");
    run_op(3'd4, 3'd5, 0, 0, 0, "R10 clear df");

    // R12 loads; fixed bits hold
    run_op(3'd5, 3'd0, 0, 16'h0000, 0, "R12 load zeros");
    run_op(3'd5, 3'd0, 0, 16'hFFFF, 0, "R12 load ones");
    run_op(3'd5, 3'd0, 0, 16'h0500, 0, "R12 load trap+direction");
    run_op(3'd4, 3'd1, 0, 16'hFFFF, 0, "R11 command keeps trap");

    // R2 idle codes
    for (int k = 0; k < 3; k++)
      run_op((k == 0) ? 3'd0 : 3'(5 + k), 3'd1, 0, 16'hFFFF, 16'h0000,
             "R2 idle class no change");

    // R3 corner: byte 7F + 01
    run_op(3'd1, 3'd7, 1, 16'h007F, 16'h0001, "R3 byte 7F+01");
    // word corners
    run_op(3'd1, 3'd7, 0, 16'h7FFF, 16'h0001, "R3 word overflow");
    run_op(3'd1, 3'd7, 0, 16'hFFFF, 16'h0001, "R3/R7 word wrap to zero");
    run_op(3'd2, 3'd7, 0, 16'h8000, 16'h0001, "R4 word overflow");
    run_op(3'd2, 3'd7, 0, 16'h0000, 16'h0001, "R4 word borrow");

    // byte sweep: every a against 20 b values, add and subtract (R3 R4 R5 R6 R7 R11)
    for (int ai = 0; ai < 256; ai++) begin
      for (int j = 0; j < 20; j++) begin
        case (j)
          16: bv = 16'h0001;
          17: bv = 16'h007F;
          18: bv = 16'h0080;
          19: bv = 16'h0008;
          default: bv = 16'(j * 17);
        endcase
        run_op(3'd1, 3'd7, 1, {8'(255 - ai), 8'(ai)}, {8'(j), bv[7:0]}, "R3/R5/R6/R7 byte add");
        run_op(3'd2, 3'd7, 1, {8'(ai + 3), 8'(ai)}, {8'(~j), bv[7:0]}, "R4/R5/R6/R7 byte sub");
      end
      run_op(3'd3, 3'd7, 1, {8'(ai), 8'(ai)}, 16'h5A00, "R8 byte logic");
    end

    // word sweep
    for (int n = 0; n < 3000; n++) begin
      wa = 16'($urandom);
      wb = 16'($urandom);
      if (n % 50 == 0) wb = wa;
      run_op(3'd1, 3'd7, 0, wa, wb, "R3/R5/R6/R7 word add");
      run_op(3'd2, 3'd7, 0, wa, wb, "R4/R6/R7 word sub");
      run_op(3'd3, 3'd7, 0, wa, wb, "R8 word logic");
      if (n % 100 == 0) run_op(3'd0, 3'd7, 0, wb, wa, "R2 none keeps");
    end

    cmp("R11 trap and direction survive", flags_o & 16'h0700, 16'h0500);
    finish_run();
  end
endmodule